// File: doc/BRIEF.md
# Seeded CRC-32 Accumulator

A coprocessor unit that keeps a 32-bit CRC residue between commands. Software loads a seed into the residue with a seed command. It then sends any number of accumulate commands. Each accumulate carries a 32-bit word and a start/end lane pair that selects which bytes of the word are folded into the residue. The selected bytes are taken most significant byte first. The residue can then be read back, for example as a hash or cache index. The polynomial is 0x04C11DB7, processed MSB-first, with no reflection and no output inversion.

Every accumulate takes a fixed number of cycles. The unit raises `busy` for that period and drops `cmd_ready`. A requester that presents a command during that time holds it until the unit accepts it. A read presented while an accumulate is in flight is therefore answered with the updated residue. Inside the window, the selected lanes are folded one byte per cycle. The result is committed at the end of the window.

Top module: `crc_accum_unit`

## Requirements
- R1: An accepted seed command (`cmd_op` = 2'b01) loads `cmd_data` into the residue at the accepting edge. It does not raise `busy`.
- R2: An accumulate command (`cmd_op` = 2'b10) folds bytes into the residue with polynomial 0x04C11DB7. Each byte is XORed into residue bits 31:24 and then shifted MSB-first for 8 steps. There is no reflection and no final XOR. Lane 0 is `cmd_data[31:24]` and lane 3 is `cmd_data[7:0]`, and lanes are processed in increasing lane order.
- R3: Only lanes from `cmd_lane_lo` up to and including `cmd_lane_hi` are folded. Other lanes are skipped, not treated as zero bytes. If `cmd_lane_lo` > `cmd_lane_hi`, the residue is left unchanged.
- R4: The residue carries over from one accumulate to the next. A series of accumulates gives the same result as one continuous byte stream.
- R5: After an accumulate is accepted, `busy` is high for exactly LATENCY (default 14) cycles. The new residue takes effect at the edge where `busy` falls.
- R6: `cmd_ready` is low while `busy` is high, and no command is accepted then. A held command is accepted at the first edge with `cmd_ready` high, which is LATENCY+1 edges after the accumulate was accepted.
- R7: An accepted read (`cmd_op` = 2'b11) gives `rd_valid` high for one cycle after the accepting edge, with `rd_data` equal to the residue at that point. A read held behind an accumulate returns the updated residue.
- R8: After reset the residue is 0, `busy` and `rd_valid` are low, and `cmd_ready` is high. A no-op command (`cmd_op` = 2'b00) is accepted and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 2 | 00 no-op, 01 seed, 10 accumulate, 11 read |
| cmd_data | input | 32 | Seed value or accumulate operand |
| cmd_lane_lo | input | 2 | First lane folded (0 = bits 31:24) |
| cmd_lane_hi | input | 2 | Last lane folded |
| cmd_ready | output | 1 | Command accepted at this edge when valid |
| busy | output | 1 | Accumulate in flight |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 32 | Residue returned by a read |

## Verification
The check value of the nine ASCII digits with an all-ones seed is tested against the known MPEG-2 style CRC. This fixes polynomial, bit order and byte order together. Single-lane, partial-range and empty-range (lo > hi) accumulates separate correct lane skipping from zero-padding and from an off-by-one error in the range. Back-to-back accumulates with a read held behind them check the carry-over, the exact stall length and the post-commit read value. A long random mix of seeds, accumulates, reads and no-ops with random lane pairs is compared against a bitwise bench model.

// File: rtl/crc_accum_pkg.sv
package crc_accum_pkg;
  localparam int CRC_W      = 32;
  localparam int BYTE_W     = 8;
  localparam int LANES      = CRC_W / BYTE_W;
  localparam int LANE_IDX_W = $clog2(LANES);
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_SEED  = 2'b01,
    OP_ACCUM = 2'b10,
    OP_READ  = 2'b11
  } crc_op_e;

  // Fold one byte into the residue, MSB-first, non-reflected.
  function automatic logic [CRC_W-1:0] crc_fold_byte(
    input logic [CRC_W-1:0]  crc_in,
    input logic [BYTE_W-1:0] data_byte
  );
    logic [CRC_W-1:0] acc;
    acc = crc_in ^ {data_byte, {(CRC_W-BYTE_W){1'b0}}};
    for (int s = 0; s < BYTE_W; s++) begin
      if (acc[CRC_W-1]) acc = (acc << 1) ^ CRC_POLY;
      else              acc = acc << 1;
    end
    return acc;
  endfunction

  // Lane 0 is the most significant byte of the word.
  function automatic logic [BYTE_W-1:0] pick_lane(
    input logic [CRC_W-1:0]      word,
    input logic [LANE_IDX_W-1:0] lane
  );
    logic [CRC_W-1:0] shifted;
    shifted = word << (int'(lane) * BYTE_W);
    return shifted[CRC_W-1 -: BYTE_W];
  endfunction
endpackage

// File: rtl/crc_latency_timer.sv
module crc_latency_timer #(
  parameter int LATENCY = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic commit
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LATENCY - 1);

  logic [CNT_W-1:0] cnt;

  assign commit = busy && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (commit) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt + 1'b1;
    end
  end

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && cnt == '0);  // R5
  AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);  // R5
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);  // R6
endmodule

// File: rtl/crc_lane_engine.sv
module crc_lane_engine
  import crc_accum_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CRC_W-1:0]      seed_crc,
  input  logic [CRC_W-1:0]      operand,
  input  logic [LANE_IDX_W-1:0] lane_lo,
  input  logic [LANE_IDX_W-1:0] lane_hi,
  output logic [CRC_W-1:0]      work_crc,
  output logic                  fold_active
);
  logic [CRC_W-1:0]      word_q;
  logic [LANE_IDX_W-1:0] idx_q;
  logic [LANE_IDX_W-1:0] hi_q;
  logic [LANE_IDX_W-1:0] lo_q;
  logic [BYTE_W-1:0]     cur_byte;
  logic                  last_lane;

  assign cur_byte  = pick_lane(word_q, idx_q);
  assign last_lane = (idx_q == hi_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q      <= '0;
      idx_q       <= '0;
      hi_q        <= '0;
      lo_q        <= '0;
      work_crc    <= '0;
      fold_active <= 1'b0;
    end else if (start) begin
      word_q      <= operand;
      idx_q       <= lane_lo;
      lo_q        <= lane_lo;
      hi_q        <= lane_hi;
      work_crc    <= seed_crc;
      fold_active <= (lane_lo <= lane_hi);
    end else if (fold_active) begin
      work_crc <= crc_fold_byte(work_crc, cur_byte);
      if (last_lane) fold_active <= 1'b0;
      else           idx_q <= idx_q + 1'b1;
    end
  end

  AST_LANE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fold_active |-> (idx_q >= lo_q) && (idx_q <= hi_q));  // R3
  AST_IDLE_KEEPS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    !fold_active && !start |=> $stable(work_crc));  // R3
endmodule

// File: rtl/crc_accum_unit.sv
module crc_accum_unit
  import crc_accum_pkg::*;
#(
  parameter int LATENCY = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [31:0] cmd_data,
  input  logic [1:0]  cmd_lane_lo,
  input  logic [1:0]  cmd_lane_hi,
  output logic        cmd_ready,
  output logic        busy,
  output logic        rd_valid,
  output logic [31:0] rd_data
);
  initial begin
    if (LATENCY < LANES + 1) $error("LATENCY must cover one cycle per lane plus one");
  end

  crc_op_e          op;
  logic             accepted;
  logic             accept_seed;
  logic             accept_accum;
  logic             accept_read;
  logic             commit_pulse;
  logic             fold_active;
  logic [CRC_W-1:0] residue;
  logic [CRC_W-1:0] work_crc;

  assign op           = crc_op_e'(cmd_op);
  assign cmd_ready    = !busy;
  assign accepted     = cmd_valid && cmd_ready;
  assign accept_seed  = accepted && (op == OP_SEED);
  assign accept_accum = accepted && (op == OP_ACCUM);
  assign accept_read  = accepted && (op == OP_READ);

  crc_latency_timer #(.LATENCY(LATENCY)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept_accum),
    .busy   (busy),
    .commit (commit_pulse)
  );

  crc_lane_engine engine_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept_accum),
    .seed_crc    (residue),
    .operand     (cmd_data),
    .lane_lo     (cmd_lane_lo),
    .lane_hi     (cmd_lane_hi),
    .work_crc    (work_crc),
    .fold_active (fold_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      residue <= '0;
    end else if (accept_seed) begin
      residue <= cmd_data;
    end else if (commit_pulse) begin
      residue <= work_crc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= accept_read;
      if (accept_read) rd_data <= residue;
    end
  end

  AST_SEED_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_seed |=> residue == $past(cmd_data) && !busy);  // R1
  AST_COMMIT_AFTER_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> !fold_active);  // R2
  AST_RESIDUE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_seed && !commit_pulse |=> $stable(residue));  // R4
  AST_ACCUM_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_accum |=> busy);  // R5
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_read |=> rd_valid && rd_data == $past(residue));  // R7
  AST_RD_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(accept_read));  // R7
endmodule

// File: tb/crc_accum_unit_tb.sv
module crc_accum_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 14;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [31:0] cmd_data = '0;
  logic [1:0]  cmd_lane_lo = '0;
  logic [1:0]  cmd_lane_hi = '0;
  logic        cmd_ready, busy, rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [31:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  crc_accum_unit #(.LATENCY(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_lane_lo(cmd_lane_lo), .cmd_lane_hi(cmd_lane_hi),
    .cmd_ready(cmd_ready), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Bit-serial model: feedback bit = residue MSB xor data bit.
  function automatic logic [31:0] m_byte(logic [31:0] c, logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[31] ^ b[i];
      c = {c[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
    end
    return c;
  endfunction

  function automatic logic [31:0] m_accum(logic [31:0] c, logic [31:0] w, int lo, int hi);
    for (int l = lo; l <= hi; l++) c = m_byte(c, 8'((w >> (8 * (3 - l))) & 32'hFF));
    return c;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Presents a command, waits for acceptance, returns at the following negedge.
  task automatic send(input logic [1:0] op, input logic [31:0] d,
                      input logic [1:0] lo, input logic [1:0] hi, output int acc_cyc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_lane_lo = lo; cmd_lane_hi = hi;
    while (!cmd_ready) @(negedge clk);
    acc_cyc = cyc + 1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic do_read(string req);
    int a;
    send(2'b11, 32'h0, 2'd0, 2'd0, a);
    check(rd_valid === 1'b1, req, 32'(rd_valid), 32'h1);
    check(rd_data === model, req, rd_data, model);
  endtask

  task automatic do_seed(logic [31:0] s);
    int a;
    send(2'b01, s, 2'd0, 2'd0, a);
    check(busy === 1'b0, "R1 seed no busy", 32'(busy), 32'h0);
    model = s;
  endtask

  task automatic do_accum(logic [31:0] w, int lo, int hi);
    int a;
    send(2'b10, w, 2'(lo), 2'(hi), a);
    if (lo <= hi) model = m_accum(model, w, lo, hi);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", cyc, 150000);
        finish_run();
      end
    end
  end

  initial begin
    int a1, a2, k;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R8 reset state
    check(cmd_ready === 1'b1 && busy === 1'b0 && rd_valid === 1'b0, "R8 reset outputs",
          {29'd0, cmd_ready, busy, rd_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    model = '0;
    do_read("R8 reset residue");

    // R1 seed then read, R8 no-op has no effect
    do_seed(32'hDEAD_BEEF);
    send(2'b00, 32'h1234_5678, 2'd0, 2'd3, a1);
    do_read("R1/R8 seed then nop");

    // R2 known check value of "123456789"
    do_seed(32'hFFFF_FFFF);
    do_accum(32'h3132_3334, 0, 3);
    do_accum(32'h3536_3738, 0, 3);
    do_accum(32'h39AA_BBCC, 0, 0);
    do_read("R2 model");
    check(rd_data === 32'h0376_E6E7, "R2 check value", rd_data, 32'h0376_E6E7);

    // R5 busy length
    do_seed(32'h0);
    send(2'b10, 32'h8000_0000, 2'd0, 2'd0, a1);
    model = m_accum(model, 32'h8000_0000, 0, 0);
    k = 0;
    while (busy === 1'b1 && k < 100) begin k++; @(negedge clk); end
    check(k == LAT, "R5 busy cycles", 32'(k), 32'(LAT));
    do_read("R2/R5 single lane");

    // R3 lane skipping vs zero padding, middle range, empty range
    do_seed(32'h1357_9BDF);
    do_accum(32'h00AB_CD00, 1, 2);
    do_read("R3 middle lanes");
    do_accum(32'hFFFF_FFFF, 3, 3);
    do_read("R3 last lane");
    do_accum(32'h1234_5678, 2, 1);
    do_read("R3 empty range");

    // R4/R6/R7 back-to-back with held read
    do_seed(32'hCAFE_0001);
    send(2'b10, 32'h0102_0304, 2'd0, 2'd3, a1);
    model = m_accum(model, 32'h0102_0304, 0, 3);
    send(2'b10, 32'hA5A5_5A5A, 2'd1, 2'd3, a2);
    model = m_accum(model, 32'hA5A5_5A5A, 1, 3);
    check(a2 - a1 == LAT + 1, "R6 stall length", 32'(a2 - a1), 32'(LAT + 1));
    send(2'b11, 32'h0, 2'd0, 2'd0, a1);
    check(a1 - a2 == LAT + 1, "R6/R7 held read accept", 32'(a1 - a2), 32'(LAT + 1));
    check(rd_valid === 1'b1 && rd_data === model, "R4/R7 held read data", rd_data, model);
    @(negedge clk);
    check(rd_valid === 1'b0, "R7 rd_valid one cycle", 32'(rd_valid), 32'h0);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int sel, lo, hi;
      logic [31:0] w;
      sel = int'($urandom_range(0, 9));
      w   = $urandom();
      lo  = int'($urandom_range(0, 3));
      hi  = int'($urandom_range(0, 3));
      if (sel == 0)      do_seed(w);
      else if (sel <= 5) do_accum(w, lo, hi);
      else if (sel <= 7) do_read("R2/R3/R4 random");
      else begin send(2'b00, w, 2'(lo), 2'(hi), a1); end
    end
    do_read("R4 random final");
    finish_run();
  end
endmodule